// File: doc/BRIEF.md
# Paravirtual I/O Device Control Register Block

This block is the register slave of a legacy paravirtual I/O device. A host reaches it through a byte-addressed access port, with access sizes of 1, 2 or 4 bytes. The block holds these registers:

- the feature words offered by the device and accepted by the driver;
- a queue selector, with a ring page number, a ring size and an interrupt vector kept for each queue;
- a device status byte;
- an interrupt status byte that clears when read.

The block drives a legacy interrupt line and a one-cycle reset pulse toward the device core. It also emits a one-cycle notify pulse that carries the written queue index.

The common header is 20 bytes long. When the message-interrupt mode is on, two vector registers are added and the header grows to 24 bytes. Any access at or above the header length is passed on, combinationally, to a device-config port. The address on that port is the offset minus the header length, and read data from that port is taken in the same cycle.

Several writes do more than store a value:
- a zero page number or a zero status byte resets the device;
- a queue select that is out of range is dropped;
- a vector the interrupt table cannot hold is stored as the sentinel 0xFFFF.

Access protocol:
- An access is one cycle with `acc_valid` high.
- The block accepts an access every cycle and applies no back-pressure.
- Read data appears on `rd_data` with `rd_valid` high exactly one cycle later.

Top module: `pvio_ctrl_regs`

## Requirements
- R1: After `rst_n` is released, the following hold until the first write: status reads 0, the driver feature word reads 0, the queue select reads 0, the config vector reads 0xFFFF, and `irq_line` is low.
- R2: A read at offset 0 returns `dev_features` with bits 24, 28 and 30 forced to one.
- R3: A write at offset 4 stores the driver feature word. If bit 30 of the written value is set, the word stored instead is `fallback_features` when `fallback_valid` is high, and 0 otherwise.
- R4: A nonzero write at offset 8 stores a page number for the selected queue. That queue's ring address becomes the value shifted left by 12, and a read at offset 8 returns the page number. A read at offset 12 returns the selected queue's size, which the core loads through `core_sz_*`.
- R5: A write at offset 14 with a value below NQ changes the queue select. A write with a value of NQ or more leaves it unchanged.
- R6: A write of 0 at offset 8, or of a status byte of 0 at offset 18, raises `dev_reset` for one cycle in place of storing the value. The reset pulse clears the status, the driver features, the queue select, the interrupt status and all page numbers, and sets all vectors to 0xFFFF. A nonzero status write is stored.
- R7: `irq_set` bits are ORed into the interrupt status byte. A read at offset 19 returns the byte and clears it to zero, keeping only the bits set in that same cycle. With `msix_en` low, `irq_line` follows bit 0 of the byte; with `msix_en` high it stays low.
- R8: With `msix_en` high, a write at offset 20 sets the config vector and a write at offset 22 sets the selected queue's vector. A written value of NVEC or more is stored as 0xFFFF, and both registers read back what was stored.
- R9: The header length is 20 bytes with `msix_en` low and 24 bytes with it high. An access at or above the header length drives `dcfg_valid` in the same cycle, with `dcfg_addr` set to the offset minus the header length. A read of that kind returns `dcfg_rdata`.
- R10: A read of any header offset that starts no readable register returns 0xFFFFFFFF.
- R11: A write at offset 16 gives, on the next cycle, a one-cycle `notify_valid` pulse with `notify_idx` equal to the low 16 bits of the written value.
- R12: Every read access produces exactly one `rd_valid` cycle, one cycle after the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | AW | Byte offset into the window |
| acc_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| acc_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | 32 | Read data |
| dcfg_valid | output | 1 | Access forwarded to the device-config area |
| dcfg_write | output | 1 | Forwarded access is a write |
| dcfg_addr | output | AW | Offset within the device-config area |
| dcfg_size | output | 2 | Forwarded access size |
| dcfg_wdata | output | 32 | Forwarded write data |
| dcfg_rdata | input | 32 | Device-config read data, same cycle |
| msix_en | input | 1 | Message-interrupt mode enable |
| dev_features | input | 32 | Feature bits of the device core |
| fallback_valid | input | 1 | A fallback feature mask is provided |
| fallback_features | input | 32 | Fallback feature mask |
| irq_set | input | 8 | Interrupt status bits to set |
| core_sz_we | input | 1 | Load a queue size |
| core_sz_idx | input | IW | Queue whose size is loaded |
| core_sz_val | input | 16 | Queue size value |
| irq_line | output | 1 | Legacy interrupt line |
| dev_reset | output | 1 | One-cycle device reset pulse |
| notify_valid | output | 1 | Queue notify pulse |
| notify_idx | output | 16 | Notified queue index |
| guest_features | output | 32 | Driver feature word |
| dev_status | output | 8 | Device status byte |
| cfg_vec | output | 16 | Config-change vector |
| qvec_flat | output | NQ*16 | Per-queue vectors, queue q at bits q*16 |
| ring_addr_flat | output | NQ*44 | Per-queue ring addresses, queue q at bits q*44 |

## Verification
The feature registers are tried with three inputs:
- a plain driver feature write;
- a write with the bad-feature bit set and no fallback, which tells apart the zero substitute from the stored value;
- a write with the bad-feature bit set and a fallback present, which tells apart the fallback from the zero substitute.

The queue registers are tried with a select of exactly NQ and with NQ-1, which separates the dropped write at the boundary from the accepted one. Page numbers written under one select are read under another, which shows they are stored per queue.

The two reset triggers are tried on their own, each after state has been loaded, so the clearing can be seen. The interrupt byte is tried with bit 0 set and with bit 1 set, in both interrupt modes. Device-config offsets are tried on both sides of the 20- and 24-byte header boundary.

// File: rtl/pvr_pkg.sv
package pvr_pkg;
  localparam int OFF_HFEAT = 0;
  localparam int OFF_GFEAT = 4;
  localparam int OFF_PFN   = 8;
  localparam int OFF_QSZ   = 12;
  localparam int OFF_QSEL  = 14;
  localparam int OFF_NTFY  = 16;
  localparam int OFF_STAT  = 18;
  localparam int OFF_ISR   = 19;
  localparam int OFF_CVEC  = 20;
  localparam int OFF_QVEC  = 22;
  localparam int HDR_PLAIN = 20;
  localparam int HDR_MSIX  = 24;
  localparam int PFN_SHIFT = 12;
  localparam int BIT_NOTIFY_EMPTY = 24;
  localparam int BIT_INDIRECT     = 28;
  localparam int BIT_BADFEAT      = 30;
  localparam logic [15:0] NO_VEC  = 16'hFFFF;

  typedef enum logic [3:0] {
    RG_NONE, RG_HFEAT, RG_GFEAT, RG_PFN, RG_QSZ, RG_QSEL,
    RG_NTFY, RG_STAT, RG_ISR, RG_CVEC, RG_QVEC
  } reg_id_e;
endpackage

// File: rtl/pvr_decode.sv
module pvr_decode
  import pvr_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic [AW-1:0] addr,
  input  logic          msix_en,
  output reg_id_e       reg_id,
  output logic          is_dev,
  output logic [AW-1:0] dev_off
);
  logic [AW-1:0] hdr_len;

  always_comb begin
    hdr_len = msix_en ? AW'(HDR_MSIX) : AW'(HDR_PLAIN);
    is_dev  = (addr >= hdr_len);
    dev_off = addr - hdr_len;
    reg_id  = RG_NONE;
    if (!is_dev) begin
      case (int'(addr))
        OFF_HFEAT: reg_id = RG_HFEAT;
        OFF_GFEAT: reg_id = RG_GFEAT;
        OFF_PFN:   reg_id = RG_PFN;
        OFF_QSZ:   reg_id = RG_QSZ;
        OFF_QSEL:  reg_id = RG_QSEL;
        OFF_NTFY:  reg_id = RG_NTFY;
        OFF_STAT:  reg_id = RG_STAT;
        OFF_ISR:   reg_id = RG_ISR;
        OFF_CVEC:  reg_id = RG_CVEC;
        OFF_QVEC:  reg_id = RG_QVEC;
        default:   reg_id = RG_NONE;
      endcase
    end
  end
endmodule

// File: rtl/pvr_queue_bank.sv
module pvr_queue_bank
  import pvr_pkg::*;
#(
  parameter int NQ  = 4,
  parameter int RAW = 32 + PFN_SHIFT,
  localparam int IW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              sel_we,
  input  logic [15:0]       sel_val,
  input  logic              pfn_we,
  input  logic [31:0]       pfn_val,
  input  logic              vec_we,
  input  logic [15:0]       vec_val,
  input  logic              sz_we,
  input  logic [IW-1:0]     sz_idx,
  input  logic [15:0]       sz_val,
  output logic [15:0]       sel_out,
  output logic [31:0]       sel_pfn,
  output logic [15:0]       sel_size,
  output logic [15:0]       sel_vec,
  output logic [NQ*16-1:0]  qvec_flat,
  output logic [NQ*RAW-1:0] ring_addr_flat
);
  logic [IW-1:0] sel;
  logic [31:0]   pfn_a  [NQ];
  logic [15:0]   vec_a  [NQ];
  logic [15:0]   size_a [NQ];

  always_ff @(posedge clk) begin
    if (!rst_n || clr)
      sel <= '0;
    else if (sel_we && (sel_val < 16'(NQ)))
      sel <= sel_val[IW-1:0];
  end

  for (genvar q = 0; q < NQ; q++) begin : g_q
    always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
        pfn_a[q] <= '0;
        vec_a[q] <= NO_VEC;
      end else if (sel == IW'(q)) begin
        if (pfn_we) pfn_a[q] <= pfn_val;
        if (vec_we) vec_a[q] <= vec_val;
      end
    end
    always_ff @(posedge clk) begin
      if (!rst_n)
        size_a[q] <= '0;
      else if (sz_we && sz_idx == IW'(q))
        size_a[q] <= sz_val;
    end
    assign qvec_flat[q*16 +: 16]       = vec_a[q];
    assign ring_addr_flat[q*RAW +: RAW] = RAW'({pfn_a[q], {PFN_SHIFT{1'b0}}});
  end

  assign sel_out  = 16'(sel);
  assign sel_pfn  = pfn_a[sel];
  assign sel_size = size_a[sel];
  assign sel_vec  = vec_a[sel];
endmodule

// File: rtl/pvr_isr.sv
module pvr_isr (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       rd_clr,
  input  logic [7:0] set,
  input  logic       msix_en,
  output logic [7:0] isr,
  output logic       irq_line
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr)
      isr <= '0;
    else if (rd_clr)
      isr <= set;
    else
      isr <= isr | set;
  end

  assign irq_line = !msix_en && isr[0];
endmodule

// File: rtl/pvio_ctrl_regs.sv
module pvio_ctrl_regs
  import pvr_pkg::*;
#(
  parameter int NQ   = 4,
  parameter int NVEC = 8,
  parameter int AW   = 8,
  localparam int IW  = (NQ > 1) ? $clog2(NQ) : 1,
  localparam int RAW = 32 + PFN_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [AW-1:0]     acc_addr,
  input  logic [1:0]        acc_size,
  input  logic [31:0]       acc_wdata,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  output logic              dcfg_valid,
  output logic              dcfg_write,
  output logic [AW-1:0]     dcfg_addr,
  output logic [1:0]        dcfg_size,
  output logic [31:0]       dcfg_wdata,
  input  logic [31:0]       dcfg_rdata,
  input  logic              msix_en,
  input  logic [31:0]       dev_features,
  input  logic              fallback_valid,
  input  logic [31:0]       fallback_features,
  input  logic [7:0]        irq_set,
  input  logic              core_sz_we,
  input  logic [IW-1:0]     core_sz_idx,
  input  logic [15:0]       core_sz_val,
  output logic              irq_line,
  output logic              dev_reset,
  output logic              notify_valid,
  output logic [15:0]       notify_idx,
  output logic [31:0]       guest_features,
  output logic [7:0]        dev_status,
  output logic [15:0]       cfg_vec,
  output logic [NQ*16-1:0]  qvec_flat,
  output logic [NQ*RAW-1:0] ring_addr_flat
);
  reg_id_e       reg_id;
  logic          is_dev;
  logic [AW-1:0] dev_off;
  logic          hw, hr, soft_clr, vec_ok;
  logic [15:0]   vec_wr, sel16, sel_size, sel_vec;
  logic [31:0]   sel_pfn, rd_mux, gf_next, host_feat;
  logic [7:0]    isr;

  pvr_decode #(.AW(AW)) u_dec (
    .addr(acc_addr), .msix_en(msix_en),
    .reg_id(reg_id), .is_dev(is_dev), .dev_off(dev_off)
  );

  assign hw = acc_valid && acc_write && !is_dev;
  assign hr = acc_valid && !acc_write && !is_dev;

  assign soft_clr = hw && (((reg_id == RG_PFN) && (acc_wdata == 32'd0)) ||
                           ((reg_id == RG_STAT) && (acc_wdata[7:0] == 8'd0)));

  assign vec_ok = acc_wdata[15:0] < 16'(NVEC);
  assign vec_wr = vec_ok ? acc_wdata[15:0] : NO_VEC;

  pvr_queue_bank #(.NQ(NQ), .RAW(RAW)) u_qb (
    .clk(clk), .rst_n(rst_n), .clr(soft_clr),
    .sel_we(hw && reg_id == RG_QSEL), .sel_val(acc_wdata[15:0]),
    .pfn_we(hw && reg_id == RG_PFN && acc_wdata != 32'd0), .pfn_val(acc_wdata),
    .vec_we(hw && reg_id == RG_QVEC), .vec_val(vec_wr),
    .sz_we(core_sz_we), .sz_idx(core_sz_idx), .sz_val(core_sz_val),
    .sel_out(sel16), .sel_pfn(sel_pfn), .sel_size(sel_size), .sel_vec(sel_vec),
    .qvec_flat(qvec_flat), .ring_addr_flat(ring_addr_flat)
  );

  pvr_isr u_isr (
    .clk(clk), .rst_n(rst_n), .clr(soft_clr),
    .rd_clr(hr && reg_id == RG_ISR), .set(irq_set), .msix_en(msix_en),
    .isr(isr), .irq_line(irq_line)
  );

  always_comb begin
    host_feat = dev_features;
    host_feat[BIT_NOTIFY_EMPTY] = 1'b1;
    host_feat[BIT_INDIRECT]     = 1'b1;
    host_feat[BIT_BADFEAT]      = 1'b1;
    if (acc_wdata[BIT_BADFEAT])
      gf_next = fallback_valid ? fallback_features : 32'd0;
    else
      gf_next = acc_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || soft_clr) begin
      guest_features <= '0;
      dev_status     <= '0;
      cfg_vec        <= NO_VEC;
    end else if (hw) begin
      if (reg_id == RG_GFEAT) guest_features <= gf_next;
      if (reg_id == RG_STAT)  dev_status     <= acc_wdata[7:0];
      if (reg_id == RG_CVEC)  cfg_vec        <= vec_wr;
    end
  end

  always_comb begin
    case (reg_id)
      RG_HFEAT: rd_mux = host_feat;
      RG_GFEAT: rd_mux = guest_features;
      RG_PFN:   rd_mux = sel_pfn;
      RG_QSZ:   rd_mux = {16'd0, sel_size};
      RG_QSEL:  rd_mux = {16'd0, sel16};
      RG_STAT:  rd_mux = {24'd0, dev_status};
      RG_ISR:   rd_mux = {24'd0, isr};
      RG_CVEC:  rd_mux = {16'd0, cfg_vec};
      RG_QVEC:  rd_mux = {16'd0, sel_vec};
      default:  rd_mux = 32'hFFFF_FFFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid     <= 1'b0;
      rd_data      <= '0;
      dev_reset    <= 1'b0;
      notify_valid <= 1'b0;
      notify_idx   <= '0;
    end else begin
      rd_valid     <= acc_valid && !acc_write;
      if (acc_valid && !acc_write)
        rd_data <= is_dev ? dcfg_rdata : rd_mux;
      dev_reset    <= soft_clr;
      notify_valid <= hw && reg_id == RG_NTFY;
      if (hw && reg_id == RG_NTFY)
        notify_idx <= acc_wdata[15:0];
    end
  end

  assign dcfg_valid = acc_valid && is_dev;
  assign dcfg_write = acc_write;
  assign dcfg_addr  = dev_off;
  assign dcfg_size  = acc_size;
  assign dcfg_wdata = acc_wdata;
endmodule

// File: rtl/pvio_ctrl_regs_chk.sv
module pvio_ctrl_regs_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_valid,
  input logic          acc_write,
  input logic [AW-1:0] acc_addr,
  input logic [31:0]   acc_wdata,
  input logic          msix_en,
  input logic [7:0]    irq_set,
  input logic          rd_valid,
  input logic          dcfg_valid,
  input logic          irq_line,
  input logic          dev_reset,
  input logic          notify_valid,
  input logic [15:0]   notify_idx,
  input logic [31:0]   guest_features,
  input logic [7:0]    dev_status,
  input logic [15:0]   cfg_vec
);
  // R6
  stat_zero_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && acc_addr == AW'(18) && acc_wdata[7:0] == 8'd0) |=> dev_reset);

  // R6
  rst_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_reset |-> (dev_status == 8'd0 && guest_features == 32'd0 && cfg_vec == 16'hFFFF));

  // R7
  isr_read_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && acc_addr == AW'(19) && irq_set == 8'd0) |=> !irq_line);

  // R11
  notify_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && acc_addr == AW'(16)) |=>
      (notify_valid && notify_idx == $past(acc_wdata[15:0])));

  // R12
  read_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write) |=> rd_valid);

  // R12
  no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && !acc_write) |=> !rd_valid);

  // R9
  fwd_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_addr >= AW'(24)) |-> dcfg_valid);

  // R9
  fwd_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_addr < AW'(20)) |-> !dcfg_valid);

  // R7
  msix_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msix_en && $past(msix_en)) |-> !irq_line);
endmodule

bind pvio_ctrl_regs pvio_ctrl_regs_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_addr(acc_addr), .acc_wdata(acc_wdata), .msix_en(msix_en), .irq_set(irq_set),
  .rd_valid(rd_valid), .dcfg_valid(dcfg_valid), .irq_line(irq_line),
  .dev_reset(dev_reset), .notify_valid(notify_valid), .notify_idx(notify_idx),
  .guest_features(guest_features), .dev_status(dev_status), .cfg_vec(cfg_vec)
);

// File: tb/pvio_ctrl_regs_bench.sv
module pvio_ctrl_regs_bench;
  localparam int NQ = 4, NVEC = 8, AW = 8, IW = 2, RAW = 44;

  logic clk = 1'b0, rst_n = 1'b0;
  logic acc_valid = 0, acc_write = 0;
  logic [AW-1:0] acc_addr = '0;
  logic [1:0] acc_size = 2'd2;
  logic [31:0] acc_wdata = '0;
  logic rd_valid, dcfg_valid, dcfg_write;
  logic [31:0] rd_data, dcfg_wdata, dcfg_rdata;
  logic [AW-1:0] dcfg_addr;
  logic [1:0] dcfg_size;
  logic msix_en = 0, fallback_valid = 0;
  logic [31:0] dev_features = 32'h0000_0021, fallback_features = 32'h0000_0ABC;
  logic [7:0] irq_set = '0;
  logic core_sz_we = 0;
  logic [IW-1:0] core_sz_idx = '0;
  logic [15:0] core_sz_val = '0;
  logic irq_line, dev_reset, notify_valid;
  logic [15:0] notify_idx, cfg_vec;
  logic [31:0] guest_features;
  logic [7:0] dev_status;
  logic [NQ*16-1:0] qvec_flat;
  logic [NQ*RAW-1:0] ring_addr_flat;

  int n_tests = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  assign dcfg_rdata = {24'hA5A5A5, 8'(dcfg_addr)};

  pvio_ctrl_regs #(.NQ(NQ), .NVEC(NVEC), .AW(AW)) u_pvio_ctrl_regs (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .dcfg_valid(dcfg_valid),
    .dcfg_write(dcfg_write), .dcfg_addr(dcfg_addr), .dcfg_size(dcfg_size),
    .dcfg_wdata(dcfg_wdata), .dcfg_rdata(dcfg_rdata), .msix_en(msix_en),
    .dev_features(dev_features), .fallback_valid(fallback_valid),
    .fallback_features(fallback_features), .irq_set(irq_set),
    .core_sz_we(core_sz_we), .core_sz_idx(core_sz_idx), .core_sz_val(core_sz_val),
    .irq_line(irq_line), .dev_reset(dev_reset), .notify_valid(notify_valid),
    .notify_idx(notify_idx), .guest_features(guest_features),
    .dev_status(dev_status), .cfg_vec(cfg_vec), .qvec_flat(qvec_flat),
    .ring_addr_flat(ring_addr_flat)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as responses appear
  always @(negedge clk) begin
    if (rd_valid) begin
      if (exp_q.size() == 0) begin
        chk(0, "R12 unexpected response", 64'(rd_data), 64'd0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rd_data === e, t, 64'(rd_data), 64'(e));
      end
    end
  end

  task automatic access(input bit wr, input int addr, input logic [31:0] data);
    @(negedge clk);
    acc_valid = 1; acc_write = wr; acc_addr = AW'(addr); acc_wdata = data;
    @(posedge clk);
    #1 acc_valid = 0; acc_write = 0;
  endtask

  task automatic wr(input int addr, input logic [31:0] data);
    access(1, addr, data);
  endtask

  task automatic rd(input int addr, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    access(0, addr, 32'd0);
  endtask

  task automatic pulse_irq(input logic [7:0] bits);
    @(negedge clk);
    irq_set = bits;
    @(posedge clk);
    #1 irq_set = 0;
  endtask

  initial begin
    #200000;
    chk(0, "watchdog expired", 64'd0, 64'd1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(dev_status == 8'd0, "R1 status", 64'(dev_status), 64'd0);
    chk(guest_features == 32'd0, "R1 guest features", 64'(guest_features), 64'd0);
    chk(cfg_vec == 16'hFFFF, "R1 cfg vector", 64'(cfg_vec), 64'hFFFF);
    chk(irq_line == 1'b0, "R1 irq line", 64'(irq_line), 64'd0);
    rd(14, 32'd0, "R1 queue select");

    // R2
    rd(0, 32'h5100_0021, "R2 host features");

    // R3
    wr(4, 32'h0000_00F3);
    rd(4, 32'h0000_00F3, "R3 plain feature write");
    wr(4, 32'h4000_0001);
    rd(4, 32'd0, "R3 bad feature no fallback");
    fallback_valid = 1;
    wr(4, 32'h4000_0001);
    rd(4, 32'h0000_0ABC, "R3 bad feature fallback");

    // R4 / R5
    wr(14, 32'd2);
    wr(8, 32'h0001_2345);
    rd(8, 32'h0001_2345, "R4 page readback");
    @(negedge clk);
    chk(ring_addr_flat[2*RAW +: RAW] == 44'h0_1234_5000, "R4 ring address",
        64'(ring_addr_flat[2*RAW +: RAW]), 64'h1234_5000);
    wr(14, 32'd1);
    rd(8, 32'd0, "R4 other queue page");
    wr(14, 32'd4);
    rd(14, 32'd1, "R5 select at NQ dropped");
    wr(14, 32'd3);
    rd(14, 32'd3, "R5 select NQ-1 taken");
    @(negedge clk);
    core_sz_we = 1; core_sz_idx = 2'd3; core_sz_val = 16'd256;
    @(posedge clk);
    #1 core_sz_we = 0;
    rd(12, 32'd256, "R4 queue size");

    // R7
    pulse_irq(8'h01);
    @(negedge clk);
    chk(irq_line == 1'b1, "R7 irq line set", 64'(irq_line), 64'd1);
    rd(19, 32'h01, "R7 isr read");
    @(negedge clk);
    chk(irq_line == 1'b0, "R7 irq line after read", 64'(irq_line), 64'd0);
    rd(19, 32'h00, "R7 isr cleared");
    pulse_irq(8'h02);
    @(negedge clk);
    chk(irq_line == 1'b0, "R7 bit1 no line", 64'(irq_line), 64'd0);
    rd(19, 32'h02, "R7 isr bit1");

    // R10
    rd(2, 32'hFFFF_FFFF, "R10 undefined offset 2");
    rd(13, 32'hFFFF_FFFF, "R10 undefined offset 13");

    // R9 without message interrupts
    rd(20, 32'hA5A5_A500, "R9 dcfg offset 20 plain");

    // R8 / R9 with message interrupts
    msix_en = 1;
    wr(20, 32'd5);
    rd(20, 32'd5, "R8 cfg vector ok");
    wr(20, 32'd9);
    rd(20, 32'h0000_FFFF, "R8 cfg vector invalid");
    wr(22, 32'd7);
    rd(22, 32'd7, "R8 queue vector ok");
    wr(22, 32'd8);
    rd(22, 32'h0000_FFFF, "R8 queue vector at NVEC");
    pulse_irq(8'h01);
    @(negedge clk);
    chk(irq_line == 1'b0, "R7 line low with msix", 64'(irq_line), 64'd0);
    rd(19, 32'h01, "R7 isr in msix mode");
    rd(24, 32'hA5A5_A500, "R9 dcfg offset 24 msix");
    @(negedge clk);
    acc_valid = 1; acc_write = 1; acc_addr = 8'd26; acc_wdata = 32'hDEAD_BEEF;
    #1;
    chk(dcfg_valid && dcfg_write && dcfg_addr == 8'd2 && dcfg_wdata == 32'hDEAD_BEEF,
        "R9 forwarded write", 64'(dcfg_addr), 64'd2);
    @(posedge clk);
    #1 acc_valid = 0; acc_write = 0;
    msix_en = 0;

    // R11
    wr(16, 32'd2);
    chk(notify_valid && notify_idx == 16'd2, "R11 notify pulse", 64'(notify_idx), 64'd2);
    @(posedge clk);
    #1 chk(!notify_valid, "R11 notify one cycle", 64'(notify_valid), 64'd0);

    // R6 status zero
    wr(18, 32'h07);
    rd(18, 32'h07, "R6 status stored");
    wr(14, 32'd2);
    wr(8, 32'h0000_0077);
    wr(18, 32'h00);
    chk(dev_reset == 1'b1, "R6 reset pulse status", 64'(dev_reset), 64'd1);
    @(posedge clk);
    #1 chk(dev_reset == 1'b0, "R6 reset one cycle", 64'(dev_reset), 64'd0);
    chk(guest_features == 32'd0 && cfg_vec == 16'hFFFF, "R6 cleared regs",
        64'(guest_features), 64'd0);
    chk(ring_addr_flat[2*RAW +: RAW] == '0 && qvec_flat[3*16 +: 16] == 16'hFFFF,
        "R6 queue state cleared", 64'(ring_addr_flat[2*RAW +: RAW]), 64'd0);
    rd(14, 32'd0, "R6 select cleared");

    // R6 page zero
    wr(18, 32'h03);
    wr(8, 32'd0);
    chk(dev_reset == 1'b1, "R6 reset pulse page", 64'(dev_reset), 64'd1);
    @(negedge clk);
    chk(dev_status == 8'd0, "R6 status cleared by page", 64'(dev_status), 64'd0);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R12 missing responses", 64'(exp_q.size()), 64'd0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule